// File: doc/BRIEF.md
# Control-Word Sequencer with Exposed Branch Delay

This block is the controller of a datapath that has no instruction set. A program counter addresses an external control memory, and the word that comes back drives the datapath control lines and a constant bus directly, with no decode stage in between. Each word also holds a jump field, a block-end marker and a target address. These let the sequencer step through memory, branch on a status flag, or return to an address supplied from outside.

With the `PIPE` parameter set to 1, a control-word register follows the memory and a status register sits in front of the jump decision. The memory therefore sees the program counter one cycle before the word takes effect. As a result, exactly one further word executes after every taken jump: the branch delay is fixed at `PIPE` words and visible to whatever generates the program. Stall and interrupt requests are acted on only at the end of a block. A stall parks the sequencer in `HOLD`, where it issues idle words and the program counter stays frozen. An interrupt redirects the program counter to a fixed vector and reports the address at which the interrupted code resumes.

The controller has two states. `RUN` is the normal state: each cycle it executes a word and either steps or jumps. `HOLD` is the stalled state: it executes the all-zero idle word. The transitions are:
- `RUN` to `RUN`, by step or jump.
- `RUN` to `RUN`, by interrupt entry at a block end.
- `RUN` to `HOLD`, by stall at a block end.
- `HOLD` to `HOLD`, while the stall request stays high.
- `HOLD` to `RUN`, by release when both requests are low.
- `HOLD` to `RUN`, by interrupt entry from hold.

Top module: `ctlword_sequencer`

## Requirements
- R1: While reset is asserted, the memory address is 0, no interrupt acknowledge is given, and with `PIPE`=1 the word in effect is the all-zero idle word.
- R2: In `RUN`, when the word in effect carries no taken jump and no block end, the memory address advances by one, wrapping modulo 2^`AW`.
- R3: The word layout, from bit 0 up, is: target address (`AW` bits), block-end flag, target source (0 = target field, 1 = `ret_addr`), jump mode (2 bits), constant (`K_W` bits) and datapath control (`DP_W` bits). The constant and control fields of the word in effect appear unchanged on `konst` and `dp_ctrl`.
- R4: Jump mode 00 never jumps, 01 always jumps, 10 jumps when status is 1, and 11 jumps when status is 0. A taken jump loads the selected target into the program counter.
- R5: With the target source set to 1, a taken jump loads the value on `ret_addr`, so a function return is handled as an ordinary jump.
- R6: After a taken jump, exactly `PIPE` further words from the sequential path execute before the word at the target.
- R7: With `PIPE`=1, the jump condition uses `status_in` as it was one cycle before the jump word takes effect. With `PIPE`=0, it uses the current `status_in`.
- R8: A stall request is honoured only in `RUN` while the word in effect has its block-end flag set. While in `HOLD`, `dp_ctrl` and `konst` are 0 and the address is frozen. The sequencer returns to `RUN` once both requests are low.
- R9: An interrupt request is honoured in `RUN` only while the word in effect has its block-end flag set. When honoured, the next address is `IRQ_VEC`, `irq_ack` is high for that one cycle, and `resume_addr` holds the address the program would otherwise have continued at.
- R10: An interrupt takes priority over a stall at the same block end. An interrupt raised during `HOLD` is taken at once, with `resume_addr` equal to the frozen address.
- R11: With `PIPE`=1, the word fetched during the block-end cycle is discarded when a stall or interrupt is accepted. It is fetched again on resumption, so execution resumes at the frozen program counter rather than one past it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmem_addr | output | AW | Control memory address (program counter) |
| cmem_word | input | AW+4+K_W+DP_W | Word read from control memory at `cmem_addr` |
| status_in | input | 1 | Datapath status flag for conditional jumps |
| ret_addr | input | AW | Return address used when the target source is 1 |
| stall_req | input | 1 | Stall request, honoured at block ends |
| irq_req | input | 1 | Interrupt request, honoured at block ends |
| dp_ctrl | output | DP_W | Datapath control field of the word in effect |
| konst | output | K_W | Constant field of the word in effect |
| irq_ack | output | 1 | One-cycle pulse after interrupt entry |
| resume_addr | output | AW | Address at which the interrupted code resumes |

## Verification
The bench builds two copies side by side from one shared control-memory image: the pipelined form (`PIPE`=1) and the unpipelined form (`PIPE`=0). Both receive the same status, stall, interrupt and return-address stimulus. Running the two copies together exposes the delay slot after each jump and the one-cycle lag of the registered status in one variant, and their absence in the other. It also exercises the discarded fetch at block ends, which only the pipelined form has. The memory image places always, if-set, if-clear and return jumps next to block ends and wraps across the top of the address space, so stall and interrupt requests meet jump words, delay slots and back-to-back block ends.

// File: rtl/cwseq_pkg.sv
package cwseq_pkg;

    typedef enum logic [1:0] {
        JM_NONE   = 2'b00,
        JM_ALWAYS = 2'b01,
        JM_IFSET  = 2'b10,
        JM_IFCLR  = 2'b11
    } jmode_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } seq_state_e;

    typedef enum logic [1:0] {
        PC_STEP   = 2'b00,
        PC_VEC    = 2'b01,
        PC_RESUME = 2'b10,
        PC_KEEP   = 2'b11
    } pc_sel_e;

endpackage

// File: rtl/cwseq_word.sv
module cwseq_word #(
    parameter int CW_W = 26,
    parameter int PIPE = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CW_W-1:0] cmem_word,
    input  logic            status_in,
    input  logic            take_word,
    output logic [CW_W-1:0] ex_word,
    output logic            st_use
);

    generate
        if (PIPE != 0) begin : g_piped
            logic [CW_W-1:0] cw_q;
            logic            st_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cw_q <= '0;
                    st_q <= 1'b0;
                end else begin
                    cw_q <= take_word ? cmem_word : '0;
                    st_q <= status_in;
                end
            end

            assign ex_word = cw_q;
            assign st_use  = st_q;
        end else begin : g_direct
            assign ex_word = take_word ? cmem_word : '0;
            assign st_use  = status_in;
        end
    endgenerate

endmodule

// File: rtl/cwseq_agen.sv
module cwseq_agen
    import cwseq_pkg::*;
#(
    parameter int AW      = 6,
    parameter int PIPE    = 1,
    parameter int IRQ_VEC = 48
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pc_sel_e       sel,
    input  jmode_e        ex_jm,
    input  logic          ex_js,
    input  logic [AW-1:0] ex_tgt,
    input  logic [AW-1:0] ret_addr,
    input  logic          st_use,
    output logic [AW-1:0] pc,
    output logic          taken,
    output logic [AW-1:0] ra
);

    localparam logic [AW-1:0] VEC = IRQ_VEC[AW-1:0];

    logic [AW-1:0] pc_q;
    logic [AW-1:0] pc_inc;
    logic [AW-1:0] dest;
    logic [AW-1:0] pc_d;

    assign pc_inc = pc_q + AW'(1);
    assign dest   = ex_js ? ret_addr : ex_tgt;

    always_comb begin
        unique case (ex_jm)
            JM_NONE:   taken = 1'b0;
            JM_ALWAYS: taken = 1'b1;
            JM_IFSET:  taken = st_use;
            JM_IFCLR:  taken = !st_use;
        endcase
    end

    always_comb begin
        if (taken)          ra = dest;
        else if (PIPE != 0) ra = pc_q;
        else                ra = pc_inc;
    end

    always_comb begin
        unique case (sel)
            PC_STEP:   pc_d = taken ? dest : pc_inc;
            PC_VEC:    pc_d = VEC;
            PC_RESUME: pc_d = ra;
            PC_KEEP:   pc_d = pc_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    assign pc = pc_q;

endmodule

// File: rtl/cwseq_fsm.sv
module cwseq_fsm
    import cwseq_pkg::*;
#(
    parameter int AW   = 6,
    parameter int PIPE = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ex_eob,
    input  logic          stall_req,
    input  logic          irq_req,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] ra,
    output pc_sel_e       sel,
    output logic          take_word,
    output logic          hold,
    output logic          irq_ack,
    output logic [AW-1:0] resume_addr
);

    seq_state_e    state_q, state_d;
    logic          fetch;
    logic          ack_d;
    logic [AW-1:0] res_d;
    logic          ack_q;
    logic [AW-1:0] res_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            ack_q   <= 1'b0;
            res_q   <= '0;
        end else begin
            state_q <= state_d;
            ack_q   <= ack_d;
            res_q   <= res_d;
        end
    end

    always_comb begin
        state_d = state_q;
        sel     = PC_STEP;
        fetch   = 1'b0;
        ack_d   = 1'b0;
        res_d   = res_q;
        unique case (state_q)
            ST_RUN: begin
                if (ex_eob && irq_req) begin
                    sel   = PC_VEC;
                    ack_d = 1'b1;
                    res_d = ra;
                end else if (ex_eob && stall_req) begin
                    sel     = PC_RESUME;
                    state_d = ST_HOLD;
                end else begin
                    sel   = PC_STEP;
                    fetch = 1'b1;
                end
            end
            ST_HOLD: begin
                if (irq_req) begin
                    sel     = PC_VEC;
                    ack_d   = 1'b1;
                    res_d   = pc;
                    state_d = ST_RUN;
                end else if (stall_req) begin
                    sel = PC_KEEP;
                end else begin
                    sel     = PC_KEEP;
                    state_d = ST_RUN;
                end
            end
        endcase
    end

    assign take_word   = (PIPE != 0) ? fetch : (state_q == ST_RUN);
    assign hold        = (state_q == ST_HOLD);
    assign irq_ack     = ack_q;
    assign resume_addr = res_q;

    // R8
    hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_HOLD) |-> $past(ex_eob));

endmodule

// File: rtl/ctlword_sequencer.sv
module ctlword_sequencer
    import cwseq_pkg::*;
#(
    parameter int AW      = 6,
    parameter int DP_W    = 8,
    parameter int K_W     = 8,
    parameter int PIPE    = 1,
    parameter int IRQ_VEC = 48
) (
    input  logic                     clk,
    input  logic                     rst_n,
    output logic [AW-1:0]            cmem_addr,
    input  logic [AW+4+K_W+DP_W-1:0] cmem_word,
    input  logic                     status_in,
    input  logic [AW-1:0]            ret_addr,
    input  logic                     stall_req,
    input  logic                     irq_req,
    output logic [DP_W-1:0]          dp_ctrl,
    output logic [K_W-1:0]           konst,
    output logic                     irq_ack,
    output logic [AW-1:0]            resume_addr
);

    localparam int CW_W  = AW + 4 + K_W + DP_W;
    localparam int EOB_B = AW;
    localparam int JS_B  = AW + 1;
    localparam int JM_LO = AW + 2;
    localparam int K_LO  = AW + 4;
    localparam int DP_LO = AW + 4 + K_W;

    logic [CW_W-1:0] ex_word;
    logic            st_use;
    logic            take_word;
    logic            ex_eob;
    logic            ex_js;
    jmode_e          ex_jm;
    logic [AW-1:0]   ex_tgt;
    pc_sel_e         sel;
    logic            taken;
    logic [AW-1:0]   ra;
    logic [AW-1:0]   pc;
    logic            hold;

    assign ex_tgt = ex_word[AW-1:0];
    assign ex_eob = ex_word[EOB_B];
    assign ex_js  = ex_word[JS_B];
    assign ex_jm  = jmode_e'(ex_word[JM_LO +: 2]);

    cwseq_word #(.CW_W(CW_W), .PIPE(PIPE)) u_word (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmem_word (cmem_word),
        .status_in (status_in),
        .take_word (take_word),
        .ex_word   (ex_word),
        .st_use    (st_use)
    );

    cwseq_agen #(.AW(AW), .PIPE(PIPE), .IRQ_VEC(IRQ_VEC)) u_agen (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .ex_jm    (ex_jm),
        .ex_js    (ex_js),
        .ex_tgt   (ex_tgt),
        .ret_addr (ret_addr),
        .st_use   (st_use),
        .pc       (pc),
        .taken    (taken),
        .ra       (ra)
    );

    cwseq_fsm #(.AW(AW), .PIPE(PIPE)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ex_eob      (ex_eob),
        .stall_req   (stall_req),
        .irq_req     (irq_req),
        .pc          (pc),
        .ra          (ra),
        .sel         (sel),
        .take_word   (take_word),
        .hold        (hold),
        .irq_ack     (irq_ack),
        .resume_addr (resume_addr)
    );

    assign cmem_addr = pc;
    assign konst     = ex_word[K_LO +: K_W];
    assign dp_ctrl   = ex_word[DP_LO +: DP_W];

    // R2
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && ex_jm == JM_NONE && !ex_eob) |=> cmem_addr == $past(cmem_addr) + AW'(1));

    // R4
    jump_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && ex_jm == JM_ALWAYS && !ex_js && !ex_eob) |=> cmem_addr == $past(ex_tgt));

    // R8
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (dp_ctrl == '0 && konst == '0));

    // R8
    hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && stall_req && !irq_req) |=> $stable(cmem_addr));

    // R9
    irq_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> cmem_addr == AW'(IRQ_VEC));

endmodule

// File: tb/tb_ctlword_sequencer.sv
module tb_ctlword_sequencer;

    localparam int CLK_P  = 10;
    localparam int AW     = 6;
    localparam int DP_W   = 8;
    localparam int K_W    = 8;
    localparam int VEC    = 48;
    localparam int CW_W   = AW + 4 + K_W + DP_W;
    localparam int NCYC   = 4000;
    localparam int DEPTH  = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic status_in = 1'b0;
    logic stall_req = 1'b0;
    logic irq_req = 1'b0;
    logic [AW-1:0] ret_addr = '0;

    logic [CW_W-1:0] mem [DEPTH];

    logic [AW-1:0]   a1, a0, r1, r0;
    logic [CW_W-1:0] w1, w0;
    logic [DP_W-1:0] d1, d0;
    logic [K_W-1:0]  k1, k0;
    logic            q1, q0;

    assign w1 = mem[a1];
    assign w0 = mem[a0];

    always #(CLK_P/2) clk = ~clk;

    ctlword_sequencer #(.AW(AW), .DP_W(DP_W), .K_W(K_W), .PIPE(1), .IRQ_VEC(VEC)) dut (
        .clk(clk), .rst_n(rst_n), .cmem_addr(a1), .cmem_word(w1), .status_in(status_in),
        .ret_addr(ret_addr), .stall_req(stall_req), .irq_req(irq_req),
        .dp_ctrl(d1), .konst(k1), .irq_ack(q1), .resume_addr(r1));

    ctlword_sequencer #(.AW(AW), .DP_W(DP_W), .K_W(K_W), .PIPE(0), .IRQ_VEC(VEC)) dut_nd (
        .clk(clk), .rst_n(rst_n), .cmem_addr(a0), .cmem_word(w0), .status_in(status_in),
        .ret_addr(ret_addr), .stall_req(stall_req), .irq_req(irq_req),
        .dp_ctrl(d0), .konst(k0), .irq_ack(q0), .resume_addr(r0));

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model state, index 1 = pipelined, 0 = unpipelined
    int    mpc [2];
    int    mcw [2];
    bit    mhold [2];
    bit    mack [2];
    int    mres [2];
    bit    mst;
    string atag [2];
    string dtag [2];

    function automatic logic [CW_W-1:0] mk(int dp, int k, int jm, int js, int eob, int tgt);
        logic [7:0] dpv = dp[7:0];
        logic [7:0] kv  = k[7:0];
        logic [1:0] jv  = jm[1:0];
        logic [5:0] tv  = tgt[5:0];
        return {dpv, kv, jv, js[0], eob[0], tv};
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int exec_word(int v);
        if (v == 1) return mcw[1];
        if (mhold[0]) return 0;
        return int'(mem[mpc[0]]);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int v = 0; v < 2; v++) begin
                mpc[v] = 0; mcw[v] = 0; mhold[v] = 0; mack[v] = 0; mres[v] = 0;
                atag[v] = "R1"; dtag[v] = "R1";
            end
            mst = 0;
        end else begin
            for (int v = 0; v < 2; v++) begin
                int ex, tgt, eob, js, jm, s, tk, dest, ra, nxt;
                ex   = exec_word(v);
                tgt  = ex & 63;
                eob  = (ex >> 6) & 1;
                js   = (ex >> 7) & 1;
                jm   = (ex >> 8) & 3;
                s    = (v == 1) ? int'(mst) : int'(status_in);
                tk   = (jm == 1 || (jm == 2 && s == 1) || (jm == 3 && s == 0)) ? 1 : 0;
                dest = (js == 1) ? int'(ret_addr) : tgt;
                ra   = (tk == 1) ? dest : ((v == 1) ? mpc[v] : (mpc[v] + 1) % DEPTH);
                mack[v] = 0;
                nxt = 0;
                dtag[v] = "R3";
                if (!mhold[v]) begin
                    if (eob == 1 && irq_req) begin
                        mres[v] = ra; mack[v] = 1; mpc[v] = VEC;
                        atag[v] = stall_req ? "R10" : "R9";
                    end else if (eob == 1 && stall_req) begin
                        mpc[v] = ra; mhold[v] = 1;
                        atag[v] = (v == 1) ? "R11" : "R8";
                        dtag[v] = "R8";
                    end else begin
                        nxt = int'(mem[mpc[v]]);
                        if (tk == 1) begin
                            mpc[v] = dest;
                            atag[v] = (js == 1) ? "R5" : ((v == 1 && jm >= 2) ? "R7" : "R4");
                            dtag[v] = "R6";
                        end else begin
                            mpc[v] = (mpc[v] + 1) % DEPTH;
                            atag[v] = "R2";
                        end
                    end
                end else begin
                    if (irq_req) begin
                        mres[v] = mpc[v]; mack[v] = 1; mpc[v] = VEC; mhold[v] = 0;
                        atag[v] = "R10";
                    end else if (stall_req) begin
                        atag[v] = "R8"; dtag[v] = "R8";
                    end else begin
                        mhold[v] = 0; atag[v] = "R8";
                    end
                end
                mcw[v] = nxt;
            end
            mst = status_in;
        end
    end

    task automatic compare_all();
        for (int v = 0; v < 2; v++) begin
            int ex;
            ex = exec_word(v);
            chk(atag[v], v ? "addr(pipe)" : "addr(direct)", int'(v ? a1 : a0), mpc[v]);
            chk(dtag[v], v ? "dp_ctrl(pipe)" : "dp_ctrl(direct)", int'(v ? d1 : d0), (ex >> 18) & 255);
            chk(dtag[v], v ? "konst(pipe)" : "konst(direct)", int'(v ? k1 : k0), (ex >> 10) & 255);
            chk("R9", v ? "irq_ack(pipe)" : "irq_ack(direct)", int'(v ? q1 : q0), int'(mack[v]));
            chk("R9", v ? "resume(pipe)" : "resume(direct)", int'(v ? r1 : r0), mres[v]);
        end
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++)
            mem[i] = mk(i ^ 8'h5A, i * 3 + 1, 0, 0, (i % 5 == 4) ? 1 : 0, 0);
        mem[3]  = mk(8'h11, 8'h21, 1, 0, 0, 10);
        mem[12] = mk(8'h12, 8'h22, 2, 0, 0, 20);
        mem[17] = mk(8'h13, 8'h23, 3, 0, 0, 27);
        mem[22] = mk(8'h14, 8'h24, 3, 0, 0, 33);
        mem[28] = mk(8'h15, 8'h25, 2, 0, 1, 5);
        mem[35] = mk(8'h16, 8'h26, 1, 1, 0, 0);
        mem[40] = mk(8'h17, 8'h27, 1, 0, 1, 3);
        mem[50] = mk(8'h18, 8'h28, 1, 1, 1, 0);
        mem[60] = mk(8'h19, 8'h29, 0, 0, 1, 0);
    end

    initial begin
        logic [15:0] lfsr;
        int stall_cnt;
        lfsr = 16'hACE1;
        stall_cnt = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "reset addr(pipe)", int'(a1), 0);
        chk("R1", "reset addr(direct)", int'(a0), 0);
        chk("R1", "reset dp_ctrl(pipe)", int'(d1), 0);
        chk("R1", "reset konst(pipe)", int'(k1), 0);
        chk("R1", "reset irq_ack(pipe)", int'(q1), 0);
        chk("R1", "reset irq_ack(direct)", int'(q0), 0);
        rst_n = 1'b1;
        for (int c = 0; c < NCYC; c++) begin
            @(negedge clk);
            compare_all();
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            status_in = lfsr[3];
            ret_addr  = lfsr[11:6];
            if (stall_cnt > 0) begin
                stall_cnt--;
                stall_req = 1'b1;
            end else if (lfsr[10:8] == 3'd0) begin
                stall_cnt = int'(lfsr[2:0]) + 1;
                stall_req = 1'b1;
            end else begin
                stall_req = 1'b0;
            end
            irq_req = (lfsr[15:13] == 3'd5);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule